// File: doc/BRIEF.md
# Near Jump Target Calculator

This block works out the instruction pointer that a near jump lands on. A decode stage gives it a start pulse together with the jump form, the address of the instruction that follows the jump, a displacement taken from the instruction, an absolute offset already fetched from a register or memory, the operand-size attribute, and the limit of the current code segment. One clock later the block presents the new pointer, a one-cycle completion strobe, and a flag for a general-protection fault with error code zero.

Relative forms add a sign-extended displacement to the following-instruction address. Indirect forms take the fetched offset as the target. With a 16-bit operand size the upper half of the target is cleared after the add or select. If the target lies above the segment limit, the fault flag is raised and the pointer register keeps its old value. The pointer width (`IP_W`) and the short-displacement width (`SHORT_W`) are parameters. The half width used for 16-bit operation is `IP_W/2`.

Top module: `near_jump_target`

## Requirements
- R1: While reset is active, and until the first start after it, `done` and `gp_fault` are 0 and `new_ip` is 0.
- R2: `done` is 1 in exactly the cycle after a cycle in which `start` is 1, and 0 in every other cycle.
- R3: Form code 2'b00 is a short relative jump. The low `SHORT_W` bits of `disp` are sign-extended and added to `next_ip`.
- R4: Form code 2'b01 is a half-width relative jump. The low `IP_W/2` bits of `disp` are sign-extended and added to `next_ip`.
- R5: Form code 2'b10 is a full-width relative jump. All of `disp` is added to `next_ip`, and the sum wraps modulo 2^IP_W without any flag.
- R6: Form code 2'b11 is an indirect jump. The target is `offset`, and `next_ip` and `disp` have no effect.
- R7: When `opsize32` is 0, the upper `IP_W/2` bits of the target are forced to zero after the add or select. This happens before the limit check.
- R8: When `opsize32` is 1, the full-width target is used unchanged.
- R9: When the target is greater than `cs_limit`, `gp_fault` is 1 together with `done`, and `new_ip` keeps the value it had before that start.
- R10: The limit check is inclusive. A target equal to `cs_limit` is legal, is loaded into `new_ip`, and leaves `gp_fault` at 0.
- R11: `new_ip` changes only in the cycle after a start whose target passes the limit check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| start | input | 1 | Compute a target from the inputs sampled this cycle |
| form | input | 2 | Jump form: 00 short relative, 01 half relative, 10 full relative, 11 indirect |
| opsize32 | input | 1 | Operand size: 1 for full width, 0 for half width |
| next_ip | input | IP_W | Address of the instruction following the jump |
| disp | input | IP_W | Displacement from the instruction; only the low bits are used for the narrow forms |
| offset | input | IP_W | Absolute target fetched for the indirect form |
| cs_limit | input | IP_W | Highest legal offset in the code segment |
| new_ip | output | IP_W | Committed instruction pointer |
| done | output | 1 | One-cycle strobe, the cycle after start |
| gp_fault | output | 1 | Target above the limit (error code 0); valid with done |

## Verification
The bench builds the block with `IP_W` = 12 and `SHORT_W` = 3. This makes the half width 6 bits, so every short displacement and every half-width displacement can be swept against hundreds of following-instruction addresses, and every indirect offset can be applied under both operand sizes. At this width, wraparound at the top of the pointer range, sign extension at the most negative narrow displacement, and the limit edges where the target equals the limit or is one above it can all be reached directly. The limit is varied along the sweep so that both faulting and committing outcomes occur, and the bench checks that the pointer holds across each fault.

// File: rtl/jt_pkg.sv
`timescale 1ns/1ps
package jt_pkg;
  typedef enum logic [1:0] {
    FORM_REL_SHORT = 2'b00,
    FORM_REL_HALF  = 2'b01,
    FORM_REL_FULL  = 2'b10,
    FORM_INDIRECT  = 2'b11
  } jform_e;
endpackage

// File: rtl/jt_disp_ext.sv
`timescale 1ns/1ps
// Sign-extends the displacement according to the jump form.
module jt_disp_ext
  import jt_pkg::*;
#(
  parameter int IP_W    = 32,
  parameter int SHORT_W = 8
) (
  input  jform_e            form,
  input  logic [IP_W-1:0]   disp,
  output logic [IP_W-1:0]   disp_wide
);
  localparam int HALF_W = IP_W / 2;

  logic [IP_W-1:0] short_ext;
  logic [IP_W-1:0] half_ext;

  assign short_ext = {{(IP_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign half_ext  = {{(IP_W-HALF_W){disp[HALF_W-1]}}, disp[HALF_W-1:0]};

  always_comb begin
    unique case (form)
      FORM_REL_SHORT: disp_wide = short_ext;
      FORM_REL_HALF:  disp_wide = half_ext;
      default:        disp_wide = disp;
    endcase
  end
endmodule

// File: rtl/jt_target_sel.sv
`timescale 1ns/1ps
// Forms the raw target (add or select), then applies operand-size truncation.
module jt_target_sel
  import jt_pkg::*;
#(
  parameter int IP_W = 32
) (
  input  jform_e            form,
  input  logic              opsize32,
  input  logic [IP_W-1:0]   next_ip,
  input  logic [IP_W-1:0]   disp_wide,
  input  logic [IP_W-1:0]   offset,
  output logic [IP_W-1:0]   target
);
  localparam int HALF_W  = IP_W / 2;
  localparam int UPPER_W = IP_W - HALF_W;

  logic [IP_W-1:0] sum;
  logic [IP_W-1:0] raw;

  // Modular add: carry out of the top bit is dropped.
  assign sum = next_ip + disp_wide;

  always_comb begin
    if (form == FORM_INDIRECT) raw = offset;
    else                       raw = sum;
  end

  always_comb begin
    if (opsize32) target = raw;
    else          target = {{UPPER_W{1'b0}}, raw[HALF_W-1:0]};
  end
endmodule

// File: rtl/jt_limit_cmp.sv
`timescale 1ns/1ps
// Inclusive segment-limit check.
module jt_limit_cmp #(
  parameter int IP_W = 32
) (
  input  logic [IP_W-1:0] target,
  input  logic [IP_W-1:0] cs_limit,
  output logic            over_limit
);
  assign over_limit = (target > cs_limit);
endmodule

// File: rtl/near_jump_target.sv
`timescale 1ns/1ps
module near_jump_target
  import jt_pkg::*;
#(
  parameter int IP_W    = 32,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        form,
  input  logic              opsize32,
  input  logic [IP_W-1:0]   next_ip,
  input  logic [IP_W-1:0]   disp,
  input  logic [IP_W-1:0]   offset,
  input  logic [IP_W-1:0]   cs_limit,
  output logic [IP_W-1:0]   new_ip,
  output logic              done,
  output logic              gp_fault
);
  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  // Datapath.
  jform_e          form_e;
  logic [IP_W-1:0] disp_wide;
  logic [IP_W-1:0] target;
  logic            over_limit;

  assign form_e = jform_e'(form);

  jt_disp_ext #(.IP_W(IP_W), .SHORT_W(SHORT_W)) u_disp_ext (
    .form      (form_e),
    .disp      (disp),
    .disp_wide (disp_wide)
  );

  jt_target_sel #(.IP_W(IP_W)) u_target_sel (
    .form      (form_e),
    .opsize32  (opsize32),
    .next_ip   (next_ip),
    .disp_wide (disp_wide),
    .offset    (offset),
    .target    (target)
  );

  jt_limit_cmp #(.IP_W(IP_W)) u_limit_cmp (
    .target     (target),
    .cs_limit   (cs_limit),
    .over_limit (over_limit)
  );

  // Next state.
  logic            ip_en;
  logic [IP_W-1:0] ip_d;
  logic            done_d;
  logic            fault_d;

  always_comb begin
    ip_en   = start & ~over_limit;
    ip_d    = target;
    done_d  = start;
    fault_d = start & over_limit;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done     <= 1'b0;
      gp_fault <= 1'b0;
    end else begin
      done     <= done_d;
      gp_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  new_ip <= '0;
    else if (ip_en)   new_ip <= ip_d;
  end
endmodule

// File: rtl/jt_checker.sv
`timescale 1ns/1ps
module jt_checker #(
  parameter int IP_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            opsize32,
  input logic [IP_W-1:0] cs_limit,
  input logic [IP_W-1:0] new_ip,
  input logic            done,
  input logic            gp_fault
);
  localparam int HALF_W = IP_W / 2;

  // R2
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R9
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> done);

  // R9
  fault_holds_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> $stable(new_ip));

  // R10
  commit_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gp_fault) |-> (new_ip <= $past(cs_limit)));

  // R7
  half_size_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !opsize32) |=> (gp_fault || new_ip[IP_W-1:HALF_W] == '0));

  // R11
  idle_ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(new_ip));
endmodule

bind near_jump_target jt_checker #(.IP_W(IP_W)) u_jt_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .start    (start),
  .opsize32 (opsize32),
  .cs_limit (cs_limit),
  .new_ip   (new_ip),
  .done     (done),
  .gp_fault (gp_fault)
);

// File: tb/tb_near_jump_target.sv
`timescale 1ns/1ps
module tb_near_jump_target;
  localparam int IP_W    = 12;
  localparam int SHORT_W = 3;
  localparam int HALF_W  = IP_W / 2;
  localparam int MASK    = (1 << IP_W) - 1;
  localparam int HMASK   = (1 << HALF_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      form = 2'b00;
  logic            opsize32 = 1'b0;
  logic [IP_W-1:0] next_ip = '0;
  logic [IP_W-1:0] disp = '0;
  logic [IP_W-1:0] offset = '0;
  logic [IP_W-1:0] cs_limit = '0;
  logic [IP_W-1:0] new_ip;
  logic            done;
  logic            gp_fault;

  int              n_vec = 0;
  int              n_bad = 0;
  bit              finished = 1'b0;
  logic [IP_W-1:0] exp_ip = '0;

  always #2.5 clk = ~clk;

  near_jump_target #(.IP_W(IP_W), .SHORT_W(SHORT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .form(form), .opsize32(opsize32),
    .next_ip(next_ip), .disp(disp), .offset(offset), .cs_limit(cs_limit),
    .new_ip(new_ip), .done(done), .gp_fault(gp_fault)
  );

  function automatic int sx(int v, int w);
    int m;
    m = v & ((1 << w) - 1);
    if (m[w-1]) return m - (1 << w);
    return m;
  endfunction

  function automatic int model_target(int f, bit op, int nip, int d, int off);
    int t;
    case (f)
      0:       t = nip + sx(d, SHORT_W);
      1:       t = nip + sx(d, HALF_W);
      2:       t = nip + d;
      default: t = off;
    endcase
    t = t & MASK;
    if (!op) t = t & HMASK;
    return t;
  endfunction

  // Called at a falling edge; drives one start and checks it one cycle later.
  task automatic apply(string req, int f, bit op, int nip, int d, int off, int lim);
    int  t;
    bit  flt;
    start    = 1'b1;
    form     = f[1:0];
    opsize32 = op;
    next_ip  = nip[IP_W-1:0];
    disp     = d[IP_W-1:0];
    offset   = off[IP_W-1:0];
    cs_limit = lim[IP_W-1:0];
    @(negedge clk);
    t   = model_target(f, op, nip, d, off);
    flt = (t > lim);
    if (!flt) exp_ip = t[IP_W-1:0];
    n_vec++;
    if (done !== 1'b1 || gp_fault !== flt || new_ip !== exp_ip) begin
      n_bad++;
      $display("FAIL %s: form=%0d op32=%0b nip=%0h disp=%0h off=%0h lim=%0h got done=%0b gp=%0b ip=%0h exp done=1 gp=%0b ip=%0h",
               req, f, op, nip, d, off, lim, done, gp_fault, new_ip, flt, exp_ip);
    end
  endtask

  // One idle cycle: done low, pointer held (R2, R11).
  task automatic idle_check(string req);
    start  = 1'b0;
    offset = ~offset;
    @(negedge clk);
    n_vec++;
    if (done !== 1'b0 || gp_fault !== 1'b0 || new_ip !== exp_ip) begin
      n_bad++;
      $display("FAIL %s: idle got done=%0b gp=%0b ip=%0h exp done=0 gp=0 ip=%0h",
               req, done, gp_fault, new_ip, exp_ip);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (done !== 1'b0 || gp_fault !== 1'b0 || new_ip !== '0) begin
      n_bad++;
      $display("FAIL R1: got done=%0b gp=%0b ip=%0h exp 0 0 0", done, gp_fault, new_ip);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1_R2");

    // R10 / R9 boundaries on the indirect form
    apply("R10", 3, 1'b1, 0, 0, 12'h5A3, 12'h5A3);
    apply("R9",  3, 1'b1, 0, 0, 12'h5A4, 12'h5A3);
    idle_check("R9_R11");
    apply("R10", 3, 1'b1, 0, 0, MASK, MASK);
    apply("R9",  3, 1'b1, 0, 0, 1, 0);
    // R5: wrap at the top of the range
    apply("R5", 2, 1'b1, MASK, 1, 0, MASK);
    apply("R5", 2, 1'b1, 12'h800, 12'h800, 0, MASK);
    // R3 / R4: most negative narrow displacements
    apply("R3", 0, 1'b1, 2, 12'hFF4, 0, MASK);
    apply("R4", 1, 1'b0, 12'h010, 12'hF20, 0, MASK);
    // R7: truncation happens before the limit check
    apply("R7", 2, 1'b0, 12'hFC0, 12'h045, 0, 12'h005);
    apply("R8", 2, 1'b1, 12'hFC0, 12'h045, 0, 12'h005);
    idle_check("R2_R11");

    // R3: short relative, both operand sizes
    for (int nip = 0; nip <= MASK; nip += 13)
      for (int d = 0; d < (1 << SHORT_W); d++)
        for (int op = 0; op < 2; op++) begin
          k++;
          apply(op ? "R3_R8" : "R3_R7", 0, op[0], nip, d | 12'hA50, 0, (k * 389) & MASK);
        end
    idle_check("R2_R11");

    // R4: half relative with half operand size
    for (int nip = 0; nip <= MASK; nip += 13)
      for (int d = 0; d < (1 << HALF_W); d++) begin
        k++;
        apply("R4_R7", 1, 1'b0, nip, d | 12'h3C0, 0, (k * 41) & HMASK);
      end
    idle_check("R2_R11");

    // R5: full relative with full operand size
    for (int nip = 0; nip <= MASK; nip += 13)
      for (int d = 0; d <= MASK; d += 37) begin
        k++;
        apply("R5_R8", 2, 1'b1, nip, d, 0, (k * 733 + 1024) & MASK);
      end
    idle_check("R2_R11");

    // R6: every indirect offset, both sizes, next_ip and disp varied
    for (int off = 0; off <= MASK; off++)
      for (int op = 0; op < 2; op++) begin
        k++;
        apply(op ? "R6_R8" : "R6_R7", 3, op[0], (k * 91) & MASK, (k * 57) & MASK,
              off, (k * 1237) & MASK);
      end
    idle_check("R2_R11");
    idle_check("R11");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule